// File: doc/BRIEF.md
# IDE Channel I/O Address Decoder

This block sits behind the configuration space of a two-channel IDE host controller and turns each I/O cycle address into a select for one of six register windows. The windows are the primary and secondary command blocks (eight bytes each), the primary and secondary control (alternate status) registers (one byte each), and two eight-byte bus-master register windows. Each channel decodes either at its fixed legacy addresses or at addresses taken from its base address registers. The choice is made per channel from the programming-interface byte and an unlock bit that enables the base registers.

The decoder has no register contents and no drive protocol. It reports which window an address falls in, and the offset within that window, one clock after the address is presented. A strap for single-channel builds removes every window that belongs to the second channel. A per-channel flag tells the interrupt logic whether that channel runs in native or legacy interrupt routing.

Top module: `ide_io_decoder`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every select output and `reg_idx` are 0.
- R2: The primary command block is native when `prog_if` bit 0 and `native_unlock` are both 1. Its eight-byte window then starts at `pri_cmd_bar` with the low 3 bits cleared. Otherwise it covers 0x1F0 to 0x1F7.
- R3: In native mode a channel's control register is at its control BAR with the low 2 bits cleared, plus 2. In legacy mode it is at 0x3F6 for the primary channel and 0x376 for the secondary channel. No neighbouring byte selects it.
- R4: The secondary command block is native when `prog_if` bit 2 and `native_unlock` are both 1, with its window at `sec_cmd_bar` with the low 3 bits cleared. Otherwise it covers 0x170 to 0x177.
- R5: When `io_space_en` is 0, no select output is ever asserted.
- R6: Secondary command and control decode only when `io_space_en` and `sec_chan_en` are 1 and `single_chan` is 0. When `single_chan` is 1, the channel-1 bus-master window is also off.
- R7: The bus-master base is `bm_bar` with its low 4 bits cleared. Channel 0's window covers base to base+7 and channel 1's covers base+8 to base+15. Both need `io_space_en`, and channel 1 also needs `single_chan` to be 0. `sec_chan_en` does not affect either window.
- R8: At most one select is active. When windows overlap, the fixed priority is: primary command, primary control, secondary command, secondary control, bus-master 0, bus-master 1.
- R9: `reg_idx` carries address bits [2:0] when a command block or bus-master window is selected. It is 0 when a control register is selected or nothing is selected.
- R10: A cycle with `io_vld` at 0 produces no select on the next cycle.
- R11: `pri_irq_native` is 1 exactly when the primary channel is native (R2). `sec_irq_native` is 1 exactly when the secondary channel is native (R4) and `single_chan` is 0. Both follow the configuration inputs without a clock.
- R12: Selects and `reg_idx` are registered: they reflect the address and configuration sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_space_en | input | 1 | Command register I/O space enable |
| prog_if | input | 8 | Programming-interface byte (bit 0 primary native, bit 2 secondary native) |
| native_unlock | input | 1 | Base address registers writable/used |
| sec_chan_en | input | 1 | Secondary channel enable |
| single_chan | input | 1 | Strap: only the primary channel exists |
| pri_cmd_bar | input | 16 | Primary command-block base register |
| pri_ctl_bar | input | 16 | Primary control base register |
| sec_cmd_bar | input | 16 | Secondary command-block base register |
| sec_ctl_bar | input | 16 | Secondary control base register |
| bm_bar | input | 16 | Bus-master base register |
| io_addr | input | 16 | I/O cycle address |
| io_vld | input | 1 | I/O cycle valid strobe |
| pri_cmd_sel | output | 1 | Primary command block selected |
| pri_ctl_sel | output | 1 | Primary control register selected |
| sec_cmd_sel | output | 1 | Secondary command block selected |
| sec_ctl_sel | output | 1 | Secondary control register selected |
| bm0_sel | output | 1 | Channel-0 bus-master window selected |
| bm1_sel | output | 1 | Channel-1 bus-master window selected |
| reg_idx | output | 3 | Offset within the selected window |
| pri_irq_native | output | 1 | Primary channel uses native interrupt routing |
| sec_irq_native | output | 1 | Secondary channel uses native interrupt routing |

## Verification
A command-block decode and a bus-master decode can match the same address when software programs a native command BAR on top of the bus-master BAR. The bench sets up exactly this case twice. In the first, the primary command BAR equals the bus-master base. In the second, the secondary command BAR lands on the channel-1 bus-master half. The scoreboard expects only the higher-priority command select, together with that window's offset. The same address is then replayed with the command channel moved away, and the expected result becomes the bus-master select.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
   localparam int NUM_CH  = 2;
   localparam int NUM_WIN = 6;

   // Window order is also the priority order (lowest index wins).
   typedef enum logic [2:0] {
      W_PRI_CMD = 3'd0,
      W_PRI_CTL = 3'd1,
      W_SEC_CMD = 3'd2,
      W_SEC_CTL = 3'd3,
      W_BM0     = 3'd4,
      W_BM1     = 3'd5
   } win_e;

   function automatic logic [15:0] legacy_cmd(input int ch);
      return (ch == 0) ? 16'h01F0 : 16'h0170;
   endfunction

   function automatic logic [15:0] legacy_ctl(input int ch);
      return (ch == 0) ? 16'h03F6 : 16'h0376;
   endfunction
endpackage

// File: rtl/ide_chan_decode.sv
module ide_chan_decode #(
   parameter int          ADDR_W  = 16,
   parameter logic [15:0] LEG_CMD = 16'h01F0,
   parameter logic [15:0] LEG_CTL = 16'h03F6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              enable,
   input  logic              native,
   input  logic [ADDR_W-1:0] cmd_bar,
   input  logic [ADDR_W-1:0] ctl_bar,
   output logic              cmd_hit,
   output logic              ctl_hit
);
   localparam int CMD_LSB = 3;
   localparam int CTL_LSB = 2;

   if (ADDR_W < 10) begin : g_bad_width
      $error("ide_chan_decode: ADDR_W must cover the legacy control address");
   end
   if (LEG_CMD[CMD_LSB-1:0] != '0) begin : g_bad_leg
      $error("ide_chan_decode: legacy command base must be 8-byte aligned");
   end

   logic [ADDR_W-1:0] cmd_base;
   logic [ADDR_W-1:0] ctl_addr;

   always_comb begin
      if (native) begin
         cmd_base = {cmd_bar[ADDR_W-1:CMD_LSB], {CMD_LSB{1'b0}}};
         ctl_addr = {ctl_bar[ADDR_W-1:CTL_LSB], {CTL_LSB{1'b0}}} + ADDR_W'(2);
      end else begin
         cmd_base = ADDR_W'(LEG_CMD);
         ctl_addr = ADDR_W'(LEG_CTL);
      end
      cmd_hit = enable && (addr[ADDR_W-1:CMD_LSB] == cmd_base[ADDR_W-1:CMD_LSB]);
      ctl_hit = enable && (addr == ctl_addr);
   end
endmodule

// File: rtl/ide_bm_decode.sv
module ide_bm_decode #(
   parameter int ADDR_W = 16,
   parameter int NCH    = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NCH-1:0]    ch_en,
   input  logic [ADDR_W-1:0] bm_bar,
   output logic [NCH-1:0]    hit
);
   localparam int WIN_LSB  = 3;
   localparam int SEL_W    = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int BASE_LSB = WIN_LSB + SEL_W;

   if (NCH != 2) begin : g_bad_nch
      $error("ide_bm_decode: two 8-byte windows are expected");
   end

   logic base_match;
   assign base_match = (addr[ADDR_W-1:BASE_LSB] == bm_bar[ADDR_W-1:BASE_LSB]);

   for (genvar k = 0; k < NCH; k++) begin : g_win
      assign hit[k] = ch_en[k] && base_match &&
                      (addr[BASE_LSB-1:WIN_LSB] == SEL_W'(k));
   end
endmodule

// File: rtl/ide_sel_prio.sv
module ide_sel_prio #(
   parameter int N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            grant[i] = 1'b1;
            taken    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
   import ide_dec_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_space_en,
   input  logic [7:0]        prog_if,
   input  logic              native_unlock,
   input  logic              sec_chan_en,
   input  logic              single_chan,
   input  logic [ADDR_W-1:0] pri_cmd_bar,
   input  logic [ADDR_W-1:0] pri_ctl_bar,
   input  logic [ADDR_W-1:0] sec_cmd_bar,
   input  logic [ADDR_W-1:0] sec_ctl_bar,
   input  logic [ADDR_W-1:0] bm_bar,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_vld,
   output logic              pri_cmd_sel,
   output logic              pri_ctl_sel,
   output logic              sec_cmd_sel,
   output logic              sec_ctl_sel,
   output logic              bm0_sel,
   output logic              bm1_sel,
   output logic [2:0]        reg_idx,
   output logic              pri_irq_native,
   output logic              sec_irq_native
);
   localparam int IDX_W = 3;

   if (ADDR_W < 10 || ADDR_W > 32) begin : g_bad_addr
      $error("ide_io_decoder: ADDR_W out of range");
   end

   // Per-channel mode and enable
   logic [NUM_CH-1:0] ch_native;
   logic [NUM_CH-1:0] ch_en;
   logic [NUM_CH-1:0] cmd_hit;
   logic [NUM_CH-1:0] ctl_hit;
   logic [NUM_CH-1:0] bm_en;
   logic [NUM_CH-1:0] bm_hit;
   logic [ADDR_W-1:0] cmd_bar [NUM_CH];
   logic [ADDR_W-1:0] ctl_bar [NUM_CH];

   assign ch_native[0] = prog_if[0] & native_unlock;
   assign ch_native[1] = prog_if[2] & native_unlock;
   assign ch_en[0]     = io_vld & io_space_en;
   assign ch_en[1]     = io_vld & io_space_en & sec_chan_en & ~single_chan;
   assign bm_en[0]     = io_vld & io_space_en;
   assign bm_en[1]     = io_vld & io_space_en & ~single_chan;
   assign cmd_bar[0]   = pri_cmd_bar;
   assign cmd_bar[1]   = sec_cmd_bar;
   assign ctl_bar[0]   = pri_ctl_bar;
   assign ctl_bar[1]   = sec_ctl_bar;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ide_chan_decode #(
         .ADDR_W  (ADDR_W),
         .LEG_CMD (legacy_cmd(c)),
         .LEG_CTL (legacy_ctl(c))
      ) u_chan (
         .addr    (io_addr),
         .enable  (ch_en[c]),
         .native  (ch_native[c]),
         .cmd_bar (cmd_bar[c]),
         .ctl_bar (ctl_bar[c]),
         .cmd_hit (cmd_hit[c]),
         .ctl_hit (ctl_hit[c])
      );
   end

   ide_bm_decode #(
      .ADDR_W (ADDR_W),
      .NCH    (NUM_CH)
   ) u_bm (
      .addr   (io_addr),
      .ch_en  (bm_en),
      .bm_bar (bm_bar),
      .hit    (bm_hit)
   );

   // Requests in priority order
   logic [NUM_WIN-1:0] req;
   logic [NUM_WIN-1:0] grant;
   assign req = {bm_hit[1], bm_hit[0], ctl_hit[1], cmd_hit[1], ctl_hit[0], cmd_hit[0]};

   ide_sel_prio #(.N(NUM_WIN)) u_prio (
      .req   (req),
      .grant (grant)
   );

   logic [IDX_W-1:0] idx_nxt;
   always_comb begin
      if (grant[W_PRI_CMD] | grant[W_SEC_CMD] | grant[W_BM0] | grant[W_BM1])
         idx_nxt = io_addr[IDX_W-1:0];
      else
         idx_nxt = '0;
   end

   logic [NUM_WIN-1:0] sel_q;
   logic [IDX_W-1:0]   idx_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         idx_q <= '0;
      end else begin
         sel_q <= grant;
         idx_q <= idx_nxt;
      end
   end

   assign pri_cmd_sel    = sel_q[W_PRI_CMD];
   assign pri_ctl_sel    = sel_q[W_PRI_CTL];
   assign sec_cmd_sel    = sel_q[W_SEC_CMD];
   assign sec_ctl_sel    = sel_q[W_SEC_CTL];
   assign bm0_sel        = sel_q[W_BM0];
   assign bm1_sel        = sel_q[W_BM1];
   assign reg_idx        = idx_q;
   assign pri_irq_native = ch_native[0];
   assign sec_irq_native = ch_native[1] & ~single_chan;

   // Checks next to the logic they guard
   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pri_cmd_sel, pri_ctl_sel, sec_cmd_sel, sec_ctl_sel, bm0_sel, bm1_sel}));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !io_vld |=> !(pri_cmd_sel | pri_ctl_sel | sec_cmd_sel | sec_ctl_sel | bm0_sel | bm1_sel));

   p_ioen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !io_space_en |=> !(pri_cmd_sel | pri_ctl_sel | sec_cmd_sel | sec_ctl_sel | bm0_sel | bm1_sel));

   p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      single_chan |=> !(sec_cmd_sel | sec_ctl_sel | bm1_sel));

   p_ctlidx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_ctl_sel | sec_ctl_sel) |-> (reg_idx == '0));

   p_pri_beats_bm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_vld && io_space_en && cmd_hit[0]) |=> (pri_cmd_sel && !bm0_sel && !bm1_sel));
endmodule

// File: tb/ide_io_decoder_test.sv
module ide_io_decoder_test;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_space_en = 1'b0;
   logic [7:0]  prog_if = 8'h00;
   logic        native_unlock = 1'b0;
   logic        sec_chan_en = 1'b0;
   logic        single_chan = 1'b0;
   logic [15:0] pri_cmd_bar = '0, pri_ctl_bar = '0, sec_cmd_bar = '0, sec_ctl_bar = '0;
   logic [15:0] bm_bar = '0;
   logic [15:0] io_addr = '0;
   logic        io_vld = 1'b0;
   logic pri_cmd_sel, pri_ctl_sel, sec_cmd_sel, sec_ctl_sel, bm0_sel, bm1_sel;
   logic [2:0] reg_idx;
   logic pri_irq_native, sec_irq_native;

   always #(CLK_PERIOD/2) clk = ~clk;

   ide_io_decoder uut (
      .clk(clk), .rst_n(rst_n), .io_space_en(io_space_en), .prog_if(prog_if),
      .native_unlock(native_unlock), .sec_chan_en(sec_chan_en), .single_chan(single_chan),
      .pri_cmd_bar(pri_cmd_bar), .pri_ctl_bar(pri_ctl_bar), .sec_cmd_bar(sec_cmd_bar),
      .sec_ctl_bar(sec_ctl_bar), .bm_bar(bm_bar), .io_addr(io_addr), .io_vld(io_vld),
      .pri_cmd_sel(pri_cmd_sel), .pri_ctl_sel(pri_ctl_sel), .sec_cmd_sel(sec_cmd_sel),
      .sec_ctl_sel(sec_ctl_sel), .bm0_sel(bm0_sel), .bm1_sel(bm1_sel), .reg_idx(reg_idx),
      .pri_irq_native(pri_irq_native), .sec_irq_native(sec_irq_native)
   );

   typedef struct packed {
      int         stamp;
      logic [5:0] sel;
      logic [2:0] idx;
      int         req;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [5:0] got_sel();
      return {bm1_sel, bm0_sel, sec_ctl_sel, sec_cmd_sel, pri_ctl_sel, pri_cmd_sel};
   endfunction

   // Reference model written from the requirements (bit 0 = primary command)
   function automatic exp_t model(input logic [15:0] a, input logic v, input int r);
      exp_t e;
      logic pn, sn, pe, se, b1e;
      logic [5:0] raw;
      pn  = prog_if[0] & native_unlock;
      sn  = prog_if[2] & native_unlock;
      pe  = v & io_space_en;
      se  = pe & sec_chan_en & ~single_chan;
      b1e = pe & ~single_chan;
      raw[0] = pe & (pn ? (a[15:3] == pri_cmd_bar[15:3]) : (a[15:3] == 13'h03E));
      raw[1] = pe & (a == (pn ? {pri_ctl_bar[15:2], 2'b10} : 16'h03F6));
      raw[2] = se & (sn ? (a[15:3] == sec_cmd_bar[15:3]) : (a[15:3] == 13'h02E));
      raw[3] = se & (a == (sn ? {sec_ctl_bar[15:2], 2'b10} : 16'h0376));
      raw[4] = pe & (a[15:4] == bm_bar[15:4]) & ~a[3];
      raw[5] = b1e & (a[15:4] == bm_bar[15:4]) & a[3];
      e.sel = '0;
      for (int i = 0; i < 6; i++) begin
         if (raw[i] && e.sel == '0) e.sel[i] = 1'b1;
      end
      e.idx = (e.sel[0] | e.sel[2] | e.sel[4] | e.sel[5]) ? a[2:0] : 3'd0;
      e.req = r;
      e.stamp = 0;
      return e;
   endfunction

   // Driver: presents one cycle and queues its expectation (R12 latency)
   task automatic drive(input logic [15:0] a, input logic v, input int r);
      exp_t e;
      @(negedge clk);
      io_addr = a;
      io_vld  = v;
      e = model(a, v, r);
      e.stamp = cyc;
      q.push_back(e);
   endtask

   // Monitor: compares items one rising edge after they were driven
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].stamp < cyc) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (got_sel() !== e.sel || reg_idx !== e.idx) begin
            fails++;
            $display("FAIL R%0d: sel=%b idx=%0d expected sel=%b idx=%0d",
                     e.req, got_sel(), reg_idx, e.sel, e.idx);
         end
      end
   end

   task automatic check_irq();
      logic ep, es;
      #1;
      ep = prog_if[0] & native_unlock;
      es = prog_if[2] & native_unlock & ~single_chan;
      checks++;
      if (pri_irq_native !== ep || sec_irq_native !== es) begin
         fails++;
         $display("FAIL R11: irq pri=%b sec=%b expected pri=%b sec=%b",
                  pri_irq_native, sec_irq_native, ep, es);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(16'h0000, 1'b0, 10);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state, with a matching address present
      io_space_en = 1'b1; sec_chan_en = 1'b1; io_addr = 16'h01F0; io_vld = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (got_sel() !== 6'b0 || reg_idx !== 3'd0) begin
         fails++;
         $display("FAIL R1: sel=%b idx=%0d expected sel=000000 idx=0", got_sel(), reg_idx);
      end
      rst_n = 1'b1;
      io_vld = 1'b0;
      check_irq();

      // R2/R9 legacy primary command block and its edges
      for (int i = 0; i < 8; i++) drive(16'h01F0 + 16'(i), 1'b1, 2);
      drive(16'h01F8, 1'b1, 2);
      drive(16'h01EF, 1'b1, 2);
      // R3 legacy control registers, neighbours do not hit
      drive(16'h03F6, 1'b1, 3);
      drive(16'h03F7, 1'b1, 3);
      drive(16'h03F5, 1'b1, 3);
      drive(16'h0376, 1'b1, 3);
      // R4 legacy secondary
      drive(16'h0170, 1'b1, 4);
      drive(16'h0175, 1'b1, 4);
      drive(16'h0178, 1'b1, 4);
      // R10 strobe low
      drive(16'h01F3, 1'b0, 10);
      drive(16'h0376, 1'b0, 10);

      // R7 bus-master windows, low nibble of the BAR ignored
      @(negedge clk); bm_bar = 16'hC00F;
      drive(16'hC000, 1'b1, 7);
      drive(16'hC007, 1'b1, 7);
      drive(16'hC008, 1'b1, 7);
      drive(16'hC00F, 1'b1, 7);
      drive(16'hC010, 1'b1, 7);
      // R7: sec_chan_en does not gate bus-master channel 1
      @(negedge clk); sec_chan_en = 1'b0;
      drive(16'hC00A, 1'b1, 7);
      drive(16'h0170, 1'b1, 6);
      drive(16'h0376, 1'b1, 6);
      drive(16'h01F1, 1'b1, 6);
      @(negedge clk); sec_chan_en = 1'b1;

      // R6 single-channel strap
      @(negedge clk); single_chan = 1'b1;
      drive(16'h0172, 1'b1, 6);
      drive(16'h0376, 1'b1, 6);
      drive(16'hC009, 1'b1, 6);
      drive(16'hC001, 1'b1, 6);
      drive(16'h03F6, 1'b1, 6);
      @(negedge clk); single_chan = 1'b0;

      // R5 I/O space disabled
      @(negedge clk); io_space_en = 1'b0;
      drive(16'h01F0, 1'b1, 5);
      drive(16'h03F6, 1'b1, 5);
      drive(16'hC000, 1'b1, 5);
      @(negedge clk); io_space_en = 1'b1;

      // R2: native bit without unlock stays legacy
      @(negedge clk);
      prog_if = 8'h05; pri_cmd_bar = 16'h1003; pri_ctl_bar = 16'h2005;
      sec_cmd_bar = 16'h1107; sec_ctl_bar = 16'h2103;
      check_irq();
      drive(16'h01F4, 1'b1, 2);
      drive(16'h1004, 1'b1, 2);

      // R2/R3/R4 native decoding
      @(negedge clk); native_unlock = 1'b1;
      check_irq();
      drive(16'h1000, 1'b1, 2);
      drive(16'h1006, 1'b1, 2);
      drive(16'h01F0, 1'b1, 2);
      drive(16'h2006, 1'b1, 3);
      drive(16'h2005, 1'b1, 3);
      drive(16'h03F6, 1'b1, 3);
      drive(16'h1103, 1'b1, 4);
      drive(16'h0170, 1'b1, 4);
      drive(16'h2102, 1'b1, 3);
      // R11 with strap
      @(negedge clk); single_chan = 1'b1;
      check_irq();
      @(negedge clk); single_chan = 1'b0;
      // Mixed mode: primary legacy, secondary native
      @(negedge clk); prog_if = 8'h04;
      check_irq();
      drive(16'h01F2, 1'b1, 2);
      drive(16'h1002, 1'b1, 2);
      drive(16'h1101, 1'b1, 4);

      // R8 overlap: primary command on the bus-master base
      @(negedge clk); prog_if = 8'h05; pri_cmd_bar = 16'hC000; sec_cmd_bar = 16'hC008;
      drive(16'hC003, 1'b1, 8);
      drive(16'hC00E, 1'b1, 8);
      // primary control over a secondary command address
      @(negedge clk); pri_ctl_bar = 16'hC00C;
      drive(16'hC00E, 1'b1, 8);
      // move command blocks away: bus-master wins again
      @(negedge clk); pri_cmd_bar = 16'h1000; sec_cmd_bar = 16'h1100; pri_ctl_bar = 16'h2004;
      drive(16'hC003, 1'b1, 8);
      drive(16'hC00E, 1'b1, 8);
      // R12: a hit followed by an idle cycle clears
      drive(16'h1005, 1'b1, 12);
      idle(3);

      @(negedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule